// File: doc/BRIEF.md
# Lockable Cache Victim Selector

This block picks which way of a 64-way set-associative cache a line fill overwrites. Each fill request produces a registered victim way index with a one-cycle valid strobe. The victim is drawn from one of two schemes, chosen at run time by a mode pin. The first is a round-robin pointer. The second is a free-running pseudo-random shift register whose value is folded into the allowed range.

The low ways of the cache can be pinned. A lockdown base B marks ways 0..B-1 as locked, and neither scheme may ever name a locked way. B is loaded through a strobe. When a new base is loaded, a round-robin pointer that would fall inside the locked region is raised to B. A load and a fill in the same cycle are served with the new base already applied.

The victim output is a plain strobe with no back-pressure. The consumer (the line-fill sequencer) must take the index in the cycle `victim_valid_o` is high. The index stays on `victim_way_o` until the next victim is issued. A fill occupies its way for eight word writes, so at most one request is expected every few cycles. The block still accepts one request per cycle. The way count is assumed to be a power of two.

Top module: `victim_sel`

## Requirements
- R1: After reset, `victim_valid_o` is 0 and `victim_way_o` is 0. The lockdown base and the round-robin pointer are both 0, and the random register holds 8'h01.
- R2: `victim_valid_o` is high in exactly the cycles that follow a cycle with `fill_req_i` high. In every other cycle it is low, and `victim_way_o` keeps its previous value.
- R3: Every issued victim index is at or above the lockdown base in force for its request.
- R4: With `mode_rand_i` = 0 (round-robin), the victim is the current pointer. The pointer then moves to pointer+1, or back to the base when it was 63.
- R5: The pointer changes only on a round-robin fill or a base load. Random-mode fills and idle cycles leave it where it is.
- R6: A cycle with `lock_load_i` high loads the base from `lock_base_i`. A pointer below the new base is raised to the base. A pointer at or above the new base is kept.
- R7: When `lock_load_i` and `fill_req_i` are high in the same cycle, the fill is served with the new base and the raised pointer.
- R8: The random register is 8 bits wide and steps on every clock after reset, whatever the inputs. Its next value is {r[6:0], r[7]^r[5]^r[4]^r[3]}.
- R9: With `mode_rand_i` = 1, the victim is base + r[5:0], where r is the random register's value in the request cycle. If that sum exceeds 63, the victim is the base.
- R10: With the base at 63, every victim is 63 in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_req_i | input | 1 | Line-fill request; one victim per high cycle |
| mode_rand_i | input | 1 | Replacement scheme: 0 round-robin, 1 pseudo-random |
| lock_load_i | input | 1 | Strobe that loads a new lockdown base |
| lock_base_i | input | 6 | Lockdown base B; ways below B are locked |
| victim_valid_o | output | 1 | High for one cycle when a new victim is issued |
| victim_way_o | output | 6 | Victim way index; held between issues |

## Verification
The assertions check several rules on every cycle:
- Each valid victim lies at or above the base.
- Valid follows a request by exactly one cycle, and the index holds when there is no request.
- The pointer holds when there is neither a round-robin fill nor a load, returns to the base after way 63, and lands at or above a newly loaded base.
- The random register never reaches zero.

Only the bench scenarios show the exact values:
- the round-robin sequence across a wrap;
- the same-cycle load-and-fill case;
- a pointer that is not lowered when the base drops;
- the folded random indices, including the fallback to the base;
- the pointer surviving a run of random fills.

// File: rtl/victim_sel_pkg.sv
package victim_sel_pkg;
  typedef enum logic {
    REPL_RR   = 1'b0,
    REPL_RAND = 1'b1
  } repl_mode_e;
endpackage

// File: rtl/victim_sel_lfsr.sv
module victim_sel_lfsr #(
  parameter int          W     = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h01
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;
  logic         fb;

  assign fb = ^(state_q & TAPS);

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= {state_q[W-2:0], fb};
  end

  assign state_o = state_q;

  // R8
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
endmodule

// File: rtl/victim_sel_rr_ptr.sv
module victim_sel_rr_ptr #(
  parameter int WAYS  = 64,
  parameter int IDX_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance_i,
  input  logic             load_i,
  input  logic [IDX_W-1:0] base_eff_i,
  output logic [IDX_W-1:0] ptr_eff_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WAYS - 1);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_next;

  always_comb begin
    ptr_eff_o = (ptr_q < base_eff_i) ? base_eff_i : ptr_q;
    if (!advance_i)            ptr_next = ptr_eff_o;
    else if (ptr_eff_o == LAST) ptr_next = base_eff_i;
    else                       ptr_next = ptr_eff_o + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 ptr_q <= '0;
    else if (advance_i || load_i) ptr_q <= ptr_next;
  end

  // R5
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance_i && !load_i) |=> $stable(ptr_q));

  // R4
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && ptr_eff_o == LAST) |=> ptr_q == $past(base_eff_i));

  // R6
  ptr_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !advance_i) |=> ptr_q >= $past(base_eff_i));
endmodule

// File: rtl/victim_sel_fold.sv
module victim_sel_fold #(
  parameter int WAYS   = 64,
  parameter int IDX_W  = $clog2(WAYS),
  parameter int LFSR_W = 8
) (
  input  logic [IDX_W-1:0]  base_i,
  input  logic [LFSR_W-1:0] rnd_i,
  output logic [IDX_W-1:0]  way_o
);
  localparam logic [IDX_W:0] LAST_X = (IDX_W+1)'(WAYS - 1);

  logic [IDX_W:0] sum;

  always_comb begin
    sum   = {1'b0, base_i} + {1'b0, rnd_i[IDX_W-1:0]};
    way_o = (sum <= LAST_X) ? sum[IDX_W-1:0] : base_i;
  end
endmodule

// File: rtl/victim_sel.sv
module victim_sel
  import victim_sel_pkg::*;
#(
  parameter int WAYS   = 64,
  parameter int LFSR_W = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h01,
  localparam int IDX_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_req_i,
  input  logic             mode_rand_i,
  input  logic             lock_load_i,
  input  logic [IDX_W-1:0] lock_base_i,
  output logic             victim_valid_o,
  output logic [IDX_W-1:0] victim_way_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WAYS - 1);

  repl_mode_e        mode;
  logic [IDX_W-1:0]  base_q;
  logic [IDX_W-1:0]  base_eff;
  logic [IDX_W-1:0]  ptr_eff;
  logic [IDX_W-1:0]  rnd_way;
  logic [IDX_W-1:0]  sel_way;
  logic [LFSR_W-1:0] rnd;
  logic              rr_advance;

  assign mode       = repl_mode_e'(mode_rand_i);
  assign base_eff   = lock_load_i ? lock_base_i : base_q;
  assign rr_advance = fill_req_i && (mode == REPL_RR);

  always_ff @(posedge clk) begin
    if (!rst_n)           base_q <= '0;
    else if (lock_load_i) base_q <= lock_base_i;
  end

  victim_sel_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) lfsr_i (
    .clk(clk), .rst_n(rst_n), .state_o(rnd)
  );

  victim_sel_rr_ptr #(.WAYS(WAYS), .IDX_W(IDX_W)) rr_i (
    .clk(clk), .rst_n(rst_n), .advance_i(rr_advance), .load_i(lock_load_i),
    .base_eff_i(base_eff), .ptr_eff_o(ptr_eff)
  );

  victim_sel_fold #(.WAYS(WAYS), .IDX_W(IDX_W), .LFSR_W(LFSR_W)) fold_i (
    .base_i(base_eff), .rnd_i(rnd), .way_o(rnd_way)
  );

  assign sel_way = (mode == REPL_RAND) ? rnd_way : ptr_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      victim_valid_o <= 1'b0;
      victim_way_o   <= '0;
    end else begin
      victim_valid_o <= fill_req_i;
      if (fill_req_i) victim_way_o <= sel_way;
    end
  end

  // R3
  victim_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid_o |-> victim_way_o >= base_q);

  // R2
  victim_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_i |=> victim_valid_o);

  // R2
  victim_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_req_i |=> (!victim_valid_o && $stable(victim_way_o)));

  // R6
  base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_load_i |=> base_q == $past(lock_base_i));

  // R10
  top_way_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_valid_o && base_q == LAST) |-> victim_way_o == LAST);
endmodule

// File: tb/victim_sel_tb_top.sv
module victim_sel_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fill_req = 1'b0, mode_rand = 1'b0, lock_load = 1'b0;
  logic [5:0] lock_base = '0;
  logic       victim_valid;
  logic [5:0] victim_way;

  int total = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  victim_sel dut_i (
    .clk(clk), .rst_n(rst_n), .fill_req_i(fill_req), .mode_rand_i(mode_rand),
    .lock_load_i(lock_load), .lock_base_i(lock_base),
    .victim_valid_o(victim_valid), .victim_way_o(victim_way)
  );

  // Random-register model from R8; m_used is the value seen at the last edge
  logic [7:0] m_lfsr, m_used;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_lfsr <= 8'h01;
      m_used <= 8'h01;
    end else begin
      m_used <= m_lfsr;
      m_lfsr <= {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3]};
    end
  end

  function automatic logic [5:0] fold(input logic [5:0] b, input logic [7:0] r);
    int s = int'(b) + int'(r[5:0]);
    return (s > 63) ? b : 6'(s);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic f, input logic m, input logic l, input logic [5:0] b);
    fill_req = f; mode_rand = m; lock_load = l; lock_base = b;
    @(negedge clk);
    fill_req = 1'b0; lock_load = 1'b0;
  endtask

  // {fill, mode, load, base[5:0], exp_valid, exp_way[5:0]}
  localparam int N = 15;
  localparam logic [15:0] TBL [N] = '{
    {1'b1, 1'b0, 1'b0, 6'd0,  1'b1, 6'd0},
    {1'b1, 1'b0, 1'b0, 6'd0,  1'b1, 6'd1},
    {1'b0, 1'b0, 1'b0, 6'd0,  1'b0, 6'd1},
    {1'b0, 1'b0, 1'b1, 6'd10, 1'b0, 6'd1},
    {1'b1, 1'b0, 1'b0, 6'd0,  1'b1, 6'd10},
    {1'b1, 1'b0, 1'b1, 6'd4,  1'b1, 6'd11},
    {1'b1, 1'b0, 1'b0, 6'd0,  1'b1, 6'd12},
    {1'b1, 1'b0, 1'b1, 6'd20, 1'b1, 6'd20},
    {1'b0, 1'b0, 1'b1, 6'd62, 1'b0, 6'd20},
    {1'b1, 1'b0, 1'b0, 6'd0,  1'b1, 6'd62},
    {1'b1, 1'b0, 1'b0, 6'd0,  1'b1, 6'd63},
    {1'b1, 1'b0, 1'b0, 6'd0,  1'b1, 6'd62},
    {1'b0, 1'b0, 1'b1, 6'd0,  1'b0, 6'd62},
    {1'b1, 1'b0, 1'b0, 6'd0,  1'b1, 6'd63},
    {1'b1, 1'b0, 1'b0, 6'd0,  1'b1, 6'd0}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int hits_in = 0, hits_fb = 0;
    logic [5:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid after reset", victim_valid, 0);
    chk("R1 way after reset", victim_way, 0);

    // Round-robin and lockdown vectors: R2 R4 R6 R7
    for (int i = 0; i < N; i++) begin
      step(TBL[i][15], TBL[i][14], TBL[i][13], TBL[i][12:7]);
      chk($sformatf("R2 table step %0d valid", i), victim_valid, TBL[i][6]);
      chk($sformatf("R4 R6 R7 table step %0d way", i), victim_way, TBL[i][5:0]);
    end

    // R9 at base 0, then R5: pointer (1) survives random fills
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 1'b1, 1'b0, 6'd0);
      chk("R9 random base 0", victim_way, fold(6'd0, m_used));
    end
    step(1'b0, 1'b0, 1'b0, 6'd0);
    chk("R2 idle valid low", victim_valid, 0);
    step(1'b1, 1'b0, 1'b0, 6'd0);
    chk("R5 pointer kept over random fills", victim_way, 1);

    // R9 at base 40, with idle gaps (R8: register keeps stepping)
    step(1'b0, 1'b1, 1'b1, 6'd40);
    for (int i = 0; i < 60; i++) begin
      step(1'b1, 1'b1, 1'b0, 6'd40);
      e = fold(6'd40, m_used);
      chk("R9 R3 random base 40", victim_way, e);
      if (int'(m_used[5:0]) + 40 > 63) hits_fb++; else hits_in++;
      if (i % 3 == 0) step(1'b0, 1'b1, 1'b0, 6'd40);
    end
    chk("R9 fallback exercised", hits_fb > 0, 1);
    chk("R9 in-range exercised", hits_in > 0, 1);
    step(1'b1, 1'b0, 1'b0, 6'd40);
    chk("R6 pointer raised to 40", victim_way, 40);

    // R10 base 63
    step(1'b0, 1'b0, 1'b1, 6'd63);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b0, 1'b0, 6'd0);
      chk("R10 round-robin at 63", victim_way, 63);
    end
    for (int i = 0; i < 5; i++) begin
      step(1'b1, 1'b1, 1'b0, 6'd0);
      chk("R10 random at 63", victim_way, 63);
    end

    // R1 mid-run reset clears base and pointer
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 valid in reset", victim_valid, 0);
    chk("R1 way in reset", victim_way, 0);
    rst_n = 1'b1;
    step(1'b1, 1'b0, 1'b0, 6'd0);
    chk("R1 pointer and base cleared", victim_way, 0);
    step(1'b1, 1'b1, 1'b0, 6'd0);
    chk("R8 R9 register reseeded", victim_way, fold(6'd0, m_used));

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule